// File: doc/BRIEF.md
# Page-Map Address Translator

This block turns a logical address into a physical address through a dedicated map RAM that holds one entry per page. The page-number field of the logical address selects an entry. Each entry holds a frame number and a not-resident flag. For a resident page, the frame number is placed above the unchanged offset bits and a physical-address strobe is raised. For a page marked not resident, a one-cycle fault pulse is raised instead, together with the page number that missed.

Software fills the map through a write port that takes an index, a frame and a flag. Switching to another process means rewriting every entry of the table through that port. There is no table base pointer to swap. The map has no reset and is built as a synchronous, read-first RAM, so it maps onto block RAM.

Top module: `pmap_xlate`

## Requirements
- R1: While reset is high, and on every cycle after reset until the first request, `phys_valid` and `fault` are both low.
- R2: For a resident page, `phys_addr[11:0]` equals `req_laddr[11:0]` and `phys_addr[23:12]` equals the frame stored at index `req_laddr[23:12]`.
- R3: Every request is answered on the cycle after it is presented, by exactly one of `phys_valid` or `fault`. A cycle with no request produces neither output on the following cycle.
- R4: When the entry's flag is 1 (not resident), `fault` pulses for one cycle, `phys_valid` stays low, and `fault_page` shows the requested page number.
- R5: A write with `map_we` high stores `map_frame` and `map_absent` at `map_index`. Every later lookup of that index returns the stored value.
- R6: A write to the same index as a lookup in the same cycle does not affect that lookup, which sees the old entry. The next lookup of that index sees the new entry.
- R7: A complete rewrite of all entries replaces every earlier translation. Requests presented on consecutive cycles are answered in order, one per cycle.
- R8: Writing a flag of 0 over a not-resident entry makes the next lookup of that page translate instead of fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_laddr | input | 24 | Logical address of the request |
| map_we | input | 1 | Map entry write enable |
| map_index | input | 12 | Page number of the entry being written |
| map_frame | input | 12 | Frame number to store |
| map_absent | input | 1 | 1 marks the page as not resident |
| phys_valid | output | 1 | Physical address strobe, one cycle after the request |
| phys_addr | output | 24 | Frame number joined to the offset |
| fault | output | 1 | One-cycle page-fault pulse |
| fault_page | output | 12 | Page number of the faulting request |

## Verification
The hardest case to reach from the ports is a write that hits the very entry being looked up in the same cycle. Random traffic almost never lines the two indexes up across a 4096-entry map. The stimulus therefore forces this collision directly, on both a resident and a not-resident entry, and then repeats the lookup to show the new value. Random traffic is kept to a small page window so that writes and lookups still meet often. A second full-table reload followed by back-to-back lookups covers the context-switch case.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int DEF_LADDR_W = 24;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_FRAME_W = 12;

  typedef enum logic [1:0] {
    XL_IDLE  = 2'd0,
    XL_HIT   = 2'd1,
    XL_FAULT = 2'd2
  } xl_kind_e;
endpackage

// File: rtl/pmap_ram.sv
module pmap_ram #(
  parameter int IDX_W = 12,
  parameter int DAT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DAT_W-1:0] wdat,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [DAT_W-1:0] rdat
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];

  // read-first: a same-cycle write is not seen by this read
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
    if (re) rdat <= mem[ridx];
  end

  // R5: a write followed by a read of that index returns the written word
  assert_write_visible_R5: assert property (@(posedge clk) disable iff (rst)
    (re && !we && $past(we) && ridx == $past(widx)) |=> rdat == $past(wdat, 2));
endmodule

// File: rtl/pmap_stage.sv
module pmap_stage #(
  parameter int OFF_W  = 12,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic              pend_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= req_in;
    end
    off_q  <= off_in;
    page_q <= page_in;
  end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
#(
  parameter int LADDR_W = DEF_LADDR_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int FRAME_W = DEF_FRAME_W,
  localparam int PAGE_W  = LADDR_W - OFF_W,
  localparam int PADDR_W = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_laddr,
  input  logic               map_we,
  input  logic [PAGE_W-1:0]  map_index,
  input  logic [FRAME_W-1:0] map_frame,
  input  logic               map_absent,
  output logic               phys_valid,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               fault,
  output logic [PAGE_W-1:0]  fault_page
);
  localparam int ENT_W = FRAME_W + 1;

  logic [ENT_W-1:0]  ent_rd;
  logic              pend_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_q;
  xl_kind_e          kind;

  pmap_ram #(.IDX_W(PAGE_W), .DAT_W(ENT_W)) u_map (
    .clk  (clk),
    .rst  (rst),
    .we   (map_we),
    .widx (map_index),
    .wdat ({map_absent, map_frame}),
    .re   (req_valid),
    .ridx (req_laddr[LADDR_W-1:OFF_W]),
    .rdat (ent_rd)
  );

  pmap_stage #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .req_in  (req_valid),
    .off_in  (req_laddr[OFF_W-1:0]),
    .page_in (req_laddr[LADDR_W-1:OFF_W]),
    .pend_q  (pend_q),
    .off_q   (off_q),
    .page_q  (page_q)
  );

  always_comb begin
    if (!pend_q)             kind = XL_IDLE;
    else if (ent_rd[FRAME_W]) kind = XL_FAULT;
    else                     kind = XL_HIT;
  end

  assign phys_valid = (kind == XL_HIT);
  assign fault      = (kind == XL_FAULT);
  assign phys_addr  = {ent_rd[FRAME_W-1:0], off_q};
  assign fault_page = page_q;

  // R2: offset bits pass through from the request one cycle earlier
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
    phys_valid |-> phys_addr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0]));

  // R3: no response without a request in the previous cycle
  assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    (phys_valid || fault) |-> $past(req_valid));

  // R4: fault reports the page that was requested
  assert_fault_page_R4: assert property (@(posedge clk) disable iff (rst)
    fault |-> fault_page == $past(req_laddr[LADDR_W-1:OFF_W]));
endmodule

// File: tb/sim_pmap_xlate.sv
module sim_pmap_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_laddr = '0;
  logic        map_we = 1'b0;
  logic [11:0] map_index = '0;
  logic [11:0] map_frame = '0;
  logic        map_absent = 1'b0;
  logic        phys_valid;
  logic [23:0] phys_addr;
  logic        fault;
  logic [11:0] fault_page;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] mdl [4096];
  bit          p_valid = 0;
  logic [12:0] p_ent;
  logic [23:0] p_la;
  string       p_tag = "R1";

  always #2.5 clk = ~clk;

  pmap_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
    .map_we(map_we), .map_index(map_index), .map_frame(map_frame),
    .map_absent(map_absent), .phys_valid(phys_valid), .phys_addr(phys_addr),
    .fault(fault), .fault_page(fault_page)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit rq, input logic [23:0] la, input bit we,
                     input logic [11:0] wp, input logic [11:0] wf,
                     input bit wa, input string tag);
    @(negedge clk);
    if (p_valid && !p_ent[12]) begin
      check(p_tag, "phys_valid", 32'(phys_valid), 32'd1);
      check(p_tag, "fault", 32'(fault), 32'd0);
      check(p_tag, "phys_addr", 32'(phys_addr), 32'({p_ent[11:0], p_la[11:0]}));
    end else if (p_valid) begin
      check(p_tag, "fault", 32'(fault), 32'd1);
      check(p_tag, "phys_valid", 32'(phys_valid), 32'd0);
      check(p_tag, "fault_page", 32'(fault_page), 32'(p_la[23:12]));
    end else begin
      check(p_tag, "idle phys_valid", 32'(phys_valid), 32'd0);
      check(p_tag, "idle fault", 32'(fault), 32'd0);
    end
    req_valid  = rq;
    req_laddr  = la;
    map_we     = we;
    map_index  = wp;
    map_frame  = wf;
    map_absent = wa;
    p_valid = rq && !rst;
    p_ent   = mdl[la[23:12]];
    p_la    = la;
    p_tag   = tag;
    if (we) mdl[wp] = {wa, wf};
  endtask

  task automatic load_all(input logic [11:0] key, input int mod);
    for (int i = 0; i < 4096; i++)
      cyc(0, '0, 1, 12'(i), 12'(i) ^ key, (i % mod) == 3, "R7");
  endtask

  task automatic req(input logic [23:0] la, input string tag);
    cyc(1, la, 0, '0, '0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd20250));
    // R1: reset, outputs quiet
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, '0, '0, 0, "R1");
    rst = 1'b0;
    cyc(0, '0, 0, '0, '0, 0, "R1");
    cyc(0, '0, 0, '0, '0, 0, "R1");
    // R5: fill the map
    load_all(12'hA5C, 7);
    req(24'h003_123, "R4");          // page 3 absent
    req(24'h004_FFF, "R2");
    req(24'hFFF_000, "R2");
    req(24'h000_001, "R2");
    cyc(0, '0, 0, '0, '0, 0, "R3");
    cyc(0, '0, 0, '0, '0, 0, "R3");
    // random traffic on a small page window
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] la;
      bit rq, we;
      la = {4'h0, 8'($urandom_range(0, 31)), 12'($urandom)};
      rq = ($urandom_range(0, 3) != 0);
      we = ($urandom_range(0, 4) == 0);
      cyc(rq, la, we, 12'($urandom_range(0, 31)), 12'($urandom),
          $urandom_range(0, 3) == 0, "R5");
    end
    // R6: same-cycle write to the entry under lookup
    cyc(1, 24'h010_0AB, 1, 12'h010, 12'h777, 0, "R6");
    req(24'h010_0AC, "R6");
    cyc(1, 24'h011_055, 1, 12'h011, 12'h222, 1, "R6");
    req(24'h011_056, "R6");
    // R8: clear the not-resident flag
    cyc(0, '0, 1, 12'h020, 12'h3C3, 1, "R8");
    req(24'h020_400, "R8");
    cyc(0, '0, 1, 12'h020, 12'h3C3, 0, "R8");
    req(24'h020_400, "R8");
    // R7: context switch, then back-to-back lookups
    load_all(12'h5A3, 5);
    for (int i = 0; i < 40; i++)
      req({12'(i * 103), 12'(i * 37)}, "R7");
    cyc(0, '0, 0, '0, '0, 0, "R3");
    cyc(0, '0, 0, '0, '0, 0, "R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule